// File: doc/BRIEF.md
# Slider Position Linearizer with End Stops

This block takes a raw position along a linear touch strip and turns it into a 7-bit reported position. The raw position is an unsigned fraction of the strip length, `RAW_W` bits wide, so full scale `FULL = 2**RAW_W` stands for the whole strip. A touch flag comes in alongside it. The block reports a code from 0 to 127 that the host can use directly as a setting.

Each end of the strip has a fixed dead zone that is pinned to its end code. This makes the extreme settings easy to hit with a finger. Between the dead zones the mapping is piecewise linear. It passes through fixed anchor codes at the one-third point and the two-thirds point of the strip. The reported value is registered and changes only on cycles where the touch flag is high. When the finger lifts, the last valid value stays on the output.

A small two-state controller owns the output register. `ST_IDLE` means no finger is present, and `ST_TRACK` means a finger is present. Its transitions are:
- capture (`ST_IDLE` to `ST_TRACK`, touch rises, the register loads);
- follow (`ST_TRACK` to `ST_TRACK`, touch stays high, the register reloads every cycle);
- release (`ST_TRACK` to `ST_IDLE`, touch falls, the register holds);
- wait (`ST_IDLE` to `ST_IDLE`, no touch, the register holds).

Top module: `slider_linearizer`

## Requirements
The breakpoints use integer division with the default parameters (`RAW_W`=10, `END_PCT`=10, `ANCHOR_A`=45, `ANCHOR_B`=83):
- `EDGE_LO` = `FULL*END_PCT/100` = 102
- `NODE_A` = `FULL/3` = 341
- `NODE_B` = `2*FULL/3` = 682
- `EDGE_HI` = `FULL*(100-END_PCT)/100` = 921

- R1: After reset, `pos_out` is 0 and `touch_out` is 0.
- R2: A captured raw value with `raw_pos` <= `EDGE_LO` reports 0.
- R3: A captured raw value with `raw_pos` >= `EDGE_HI` reports 127.
- R4: A captured raw value strictly between `EDGE_LO` and `EDGE_HI` reports a value in the range 1 to 126.
- R5: A touch at `raw_pos` = `NODE_A` reports `ANCHOR_A` (45). A touch at `raw_pos` = `NODE_B` reports `ANCHOR_B` (83).
- R6: Inside the centre span the report is `y0 + floor((raw-x0)*(y1-y0)/(x1-x0))`, clamped to 1..126. The three segments use these end points:
  - (`EDGE_LO`,1) to (`NODE_A`,45) for raw up to and including `NODE_A`;
  - (`NODE_A`,45) to (`NODE_B`,83) for raw up to and including `NODE_B`;
  - (`NODE_B`,83) to (`EDGE_HI`,126) for the rest.
- R7: On every clock edge where `touch_in` is 1, `pos_out` takes the mapped value of that cycle's `raw_pos`. This holds for a single-cycle touch and for every cycle of a sustained touch.
- R8: On a clock edge where `touch_in` is 0, `pos_out` keeps its value, whatever `raw_pos` does.
- R9: `touch_out` equals the `touch_in` value sampled at the previous clock edge.
- R10: For a touch that moves steadily from 0 to `FULL-1`, the reported value never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_pos | input | RAW_W | Raw position as a fraction of the strip length |
| touch_in | input | 1 | High while a finger is present |
| pos_out | output | 7 | Reported position code, 0 to 127 |
| touch_out | output | 1 | Registered touch flag, high in `ST_TRACK` |

## Verification
The hardest situation to reach from the ports is the single raw code on each side of every breakpoint. A random raw value lands on `EDGE_LO`, `EDGE_LO+1`, `EDGE_HI-1` or `EDGE_HI` only about once in a thousand vectors. To cover these codes, the stimulus includes a full touched sweep of every raw code in rising order, which also exercises the monotonic check. It also includes directed touches on each breakpoint. The hold behaviour is reached by random touch patterns in which the raw input keeps changing while the flag is low.

// File: rtl/sl_pkg.sv
package sl_pkg;
    localparam int POS_W   = 7;
    localparam int POS_MAX = (1 << POS_W) - 1;

    typedef enum logic [2:0] {
        Z_LEFT_STOP,
        Z_SEG_A,
        Z_SEG_B,
        Z_SEG_C,
        Z_RIGHT_STOP
    } zone_t;

    typedef enum logic {
        ST_IDLE,
        ST_TRACK
    } state_t;
endpackage

// File: rtl/sl_zone_classify.sv
module sl_zone_classify
    import sl_pkg::*;
#(
    parameter int RAW_W   = 10,
    parameter int EDGE_LO = 102,
    parameter int NODE_A  = 341,
    parameter int NODE_B  = 682,
    parameter int EDGE_HI = 921
) (
    input  logic [RAW_W-1:0] raw,
    output zone_t            zone
);
    logic [31:0] raw_w;

    always_comb begin
        raw_w = 32'(raw);
        if (raw_w <= 32'(EDGE_LO))      zone = Z_LEFT_STOP;
        else if (raw_w <= 32'(NODE_A))  zone = Z_SEG_A;
        else if (raw_w <= 32'(NODE_B))  zone = Z_SEG_B;
        else if (raw_w <  32'(EDGE_HI)) zone = Z_SEG_C;
        else                            zone = Z_RIGHT_STOP;
    end
endmodule

// File: rtl/sl_segment_interp.sv
module sl_segment_interp #(
    parameter int RAW_W = 10,
    parameter int X0    = 102,
    parameter int X1    = 341,
    parameter int Y0    = 1,
    parameter int Y1    = 45
) (
    input  logic [RAW_W-1:0] raw,
    output logic [31:0]      val
);
    localparam int RUN  = X1 - X0;
    localparam int RISE = Y1 - Y0;

    logic [31:0] offs;
    logic [31:0] scaled;

    always_comb begin
        offs   = 32'(raw) - 32'(X0);
        scaled = (offs * 32'(RISE)) / 32'(RUN);
        val    = 32'(Y0) + scaled;
    end
endmodule

// File: rtl/sl_report_fsm.sv
module sl_report_fsm
    import sl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_in,
    input  logic [POS_W-1:0] mapped,
    output logic [POS_W-1:0] pos_out,
    output logic             touch_out
);
    state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = touch_in ? ST_TRACK : ST_IDLE;   // capture / wait
            ST_TRACK: state_d = touch_in ? ST_TRACK : ST_IDLE;   // follow / release
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pos_out <= '0;
        else if (touch_in) pos_out <= mapped;
    end

    assign touch_out = (state_q == ST_TRACK);

    // R7
    update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_in |=> (pos_out == $past(mapped)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_in |=> $stable(pos_out));

    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_in |=> touch_out);

    // R9
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_in |=> !touch_out);
endmodule

// File: rtl/slider_linearizer.sv
module slider_linearizer
    import sl_pkg::*;
#(
    parameter int RAW_W    = 10,
    parameter int END_PCT  = 10,
    parameter int ANCHOR_A = 45,
    parameter int ANCHOR_B = 83
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAW_W-1:0] raw_pos,
    input  logic             touch_in,
    output logic [6:0]       pos_out,
    output logic             touch_out
);
    localparam int FULL    = 1 << RAW_W;
    localparam int EDGE_LO = FULL * END_PCT / 100;
    localparam int EDGE_HI = FULL * (100 - END_PCT) / 100;
    localparam int NODE_A  = FULL / 3;
    localparam int NODE_B  = (2 * FULL) / 3;
    localparam int MID_LO  = 1;
    localparam int MID_HI  = POS_MAX - 1;

    zone_t            zone;
    logic [31:0]      seg_val [3];
    logic [POS_W-1:0] mapped;

    sl_zone_classify #(
        .RAW_W(RAW_W), .EDGE_LO(EDGE_LO), .NODE_A(NODE_A),
        .NODE_B(NODE_B), .EDGE_HI(EDGE_HI)
    ) u_zone (
        .raw  (raw_pos),
        .zone (zone)
    );

    for (genvar g = 0; g < 3; g++) begin : g_seg
        localparam int X0 = (g == 0) ? EDGE_LO : (g == 1) ? NODE_A   : NODE_B;
        localparam int X1 = (g == 0) ? NODE_A  : (g == 1) ? NODE_B   : EDGE_HI;
        localparam int Y0 = (g == 0) ? MID_LO  : (g == 1) ? ANCHOR_A : ANCHOR_B;
        localparam int Y1 = (g == 0) ? ANCHOR_A : (g == 1) ? ANCHOR_B : MID_HI;
        sl_segment_interp #(
            .RAW_W(RAW_W), .X0(X0), .X1(X1), .Y0(Y0), .Y1(Y1)
        ) u_interp (
            .raw (raw_pos),
            .val (seg_val[g])
        );
    end

    function automatic logic [POS_W-1:0] clamp_mid(input logic [31:0] v);
        if (v < 32'(MID_LO))      return POS_W'(MID_LO);
        else if (v > 32'(MID_HI)) return POS_W'(MID_HI);
        else                      return v[POS_W-1:0];
    endfunction

    always_comb begin
        unique case (zone)
            Z_LEFT_STOP:  mapped = '0;
            Z_SEG_A:      mapped = clamp_mid(seg_val[0]);
            Z_SEG_B:      mapped = clamp_mid(seg_val[1]);
            Z_SEG_C:      mapped = clamp_mid(seg_val[2]);
            Z_RIGHT_STOP: mapped = POS_W'(POS_MAX);
            default:      mapped = '0;
        endcase
    end

    sl_report_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_in  (touch_in),
        .mapped    (mapped),
        .pos_out   (pos_out),
        .touch_out (touch_out)
    );

    // R2
    left_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(raw_pos) <= 32'(EDGE_LO)) |-> (mapped == '0));

    // R3
    right_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(raw_pos) >= 32'(EDGE_HI)) |-> (mapped == POS_W'(POS_MAX)));

    // R4
    mid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(raw_pos) > 32'(EDGE_LO)) && (32'(raw_pos) < 32'(EDGE_HI)))
        |-> ((mapped >= POS_W'(MID_LO)) && (mapped <= POS_W'(MID_HI))));

    // R5
    anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(raw_pos) == 32'(NODE_A)) |-> (mapped == POS_W'(ANCHOR_A)));
endmodule

// File: tb/slider_linearizer_tb.sv
module slider_linearizer_tb;
    localparam int RAW_W = 10;
    localparam int FULL  = 1 << RAW_W;
    localparam int B0 = FULL * 10 / 100;
    localparam int B1 = FULL / 3;
    localparam int B2 = (2 * FULL) / 3;
    localparam int B3 = FULL * 90 / 100;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [RAW_W-1:0] raw_pos = '0;
    logic             touch_in = 1'b0;
    logic [6:0]       pos_out;
    logic             touch_out;

    int n_vec  = 0;
    int n_fail = 0;
    int model_pos = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    slider_linearizer #(.RAW_W(RAW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .raw_pos(raw_pos), .touch_in(touch_in),
        .pos_out(pos_out), .touch_out(touch_out)
    );

    function automatic int exp_map(input int r);
        int v;
        if (r <= B0) return 0;
        if (r >= B3) return 127;
        if (r <= B1)      v = 1  + (r - B0) * 44 / (B1 - B0);
        else if (r <= B2) v = 45 + (r - B1) * 38 / (B2 - B1);
        else              v = 83 + (r - B2) * 43 / (B3 - B2);
        if (v < 1)   v = 1;
        if (v > 126) v = 126;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int r, input bit t, input string req);
        raw_pos  = RAW_W'(r);
        touch_in = t;
        @(posedge clk);
        #1;
        if (t) model_pos = exp_map(r);
        check(int'(pos_out) == model_pos, req, int'(pos_out), model_pos);
        check(touch_out == t, "R9", int'(touch_out), int'(t));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        void'($urandom(32'd20511));
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(pos_out == 7'd0, "R1", int'(pos_out), 0);
        check(touch_out == 1'b0, "R1", int'(touch_out), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(pos_out == 7'd0, "R1", int'(pos_out), 0);

        step(1000, 1'b1, "R3");
        step(0, 1'b1, "R2");
        step(B0, 1'b1, "R2");
        step(B0 + 1, 1'b1, "R4");
        check(int'(pos_out) == 1, "R4", int'(pos_out), 1);
        step(B1, 1'b1, "R5");
        check(int'(pos_out) == 45, "R5", int'(pos_out), 45);
        step(B2, 1'b1, "R5");
        check(int'(pos_out) == 83, "R5", int'(pos_out), 83);
        step(B3 - 1, 1'b1, "R4");
        check(int'(pos_out) >= 1 && int'(pos_out) <= 126, "R4", int'(pos_out), 126);
        step(B3, 1'b1, "R3");
        step(FULL - 1, 1'b1, "R3");

        // R8: raw moves while released, output holds
        step(500, 1'b0, "R8");
        step(20, 1'b0, "R8");
        step(960, 1'b0, "R8");
        check(int'(pos_out) == 127, "R8", int'(pos_out), 127);
        // R7: single-cycle touch captures
        step(500, 1'b1, "R7");
        step(10, 1'b0, "R8");
        check(int'(pos_out) == exp_map(500), "R7", int'(pos_out), exp_map(500));

        // R6 / R10: full touched sweep
        prev = 0;
        for (int r = 0; r < FULL; r++) begin
            step(r, 1'b1, "R6");
            check(int'(pos_out) >= prev, "R10", int'(pos_out), prev);
            prev = int'(pos_out);
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit t;
            r = int'($urandom_range(FULL - 1, 0));
            t = ($urandom_range(3, 0) != 0);
            step(r, t, t ? "R7" : "R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule